// File: doc/BRIEF.md
# Near-Lossless Golomb Spike Compressor

This block compresses one channel of 9-bit signed extracellular samples into a packed bitstream. Each sample comes with a flag from an upstream spike detector. Every accepted sample first passes through a 32-sample history line, so the coder always works on the sample taken 32 inputs earlier. A detected spike can then pull its 32 pre-trigger samples into the window that gets coded.

In lossless mode every delayed sample is coded. The block forms the second-order prediction residual, folds the residual onto non-negative integers and writes a Golomb-Rice codeword. An adaptation unit counts zero residuals and retunes the Rice parameter after each block of 64 residuals. In near-lossless mode only 64-sample spike windows are coded. Every sample between windows is taken as zero and is not sent. Each window is preceded by the length of the zero run before it, split into two or three small fields that pass through the same coder.

Codewords are packed MSB-first into 16-bit words. The output uses a valid/ready handshake. When the output stalls, the input is held off with a ready signal.

Top module: `spike_golomb_compressor`

## Requirements
- R1: After reset, outValid is low and inReady is high. The history line, the prediction history and the run counter are all zero, and k equals 2.
- R2: A sample is accepted only in a cycle where inValid and inReady are both high. The sample coded at the n-th acceptance is the one accepted 32 acceptances earlier. Zeros stand in for it during the first 32 acceptances.
- R3: The residual is r = e(i) - 2*e(i-1) + e(i-2) over the effective samples e, and it is mapped to 2r when r >= 0 and to -2r-1 when r < 0.
- R4: A symbol v is coded with q = v >> k. If q <= 16 the code is q one-bits, a zero-bit, then the k low bits of v MSB-first. If q > 16 the code is 17 one-bits followed by v as a raw 11-bit value, MSB-first.
- R5: After every 64 coded residuals, k is reloaded from the zero count z of that block: z>=48 gives 0, z>=32 gives 1, z>=16 gives 2, z>=8 gives 3, z>=4 gives 4, z>=2 gives 5, z>=1 gives 6, and 7 otherwise. Run-length fields neither count nor change k.
- R6: In near-lossless mode, a flag on an accepted sample while no window is open starts a 64-sample window, and the delayed sample accepted in that same cycle is the first sample of the window. Flags inside a window are ignored. Samples outside a window are not coded and enter the prediction history as zero.
- R7: At each window start the run length R of zero samples since the last window is coded before the first window residual. If R < 512, two fields are sent: {0,R[8:5]} then R[4:0]. Otherwise three fields are sent: {1,R[13:10]}, then R[9:5], then R[4:0]. R then restarts at zero.
- R8: The run length saturates at 16383.
- R9: The mode input is taken only on acceptances where no window is open, so a window always completes in near-lossless mode. An acceptance in lossless mode clears the run length.
- R10: Bits are packed MSB-first into 16-bit words. outValid is high whenever at least 16 bits are waiting. While outValid is high and outReady is low, outWord holds its value.
- R11: When the output stalls, inReady drops so that no sample or codeword is lost. Throttling outReady leaves the word sequence unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| inValid | input | 1 | Sample present |
| inReady | output | 1 | Block can take a sample this cycle |
| inSample | input | 9 | Signed sample |
| inSpike | input | 1 | Spike flag for this sample |
| cfgNearLossless | input | 1 | 1 selects near-lossless, 0 selects lossless |
| outValid | output | 1 | outWord holds a full packed word |
| outReady | input | 1 | Downstream takes the word |
| outWord | output | 16 | Packed bits, earliest bit in bit 15 |

## Verification
Some behaviours are checked by assertions on every cycle. The output word must hold steady under stall. The control may push a codeword only when the packer has room. The Rice parameter may change only on a residual push. An open window keeps the latched mode and is only ever open in near-lossless mode. The bit-exact content of the stream can only be shown by the bench's scenarios, which compare every word against an independent model. That content covers the 32-sample delay, the residual mapping, escape codes, the adaptation table, the two- and three-field run forms, run saturation, ignored flags inside a window and deferred mode changes.

// File: rtl/sgc_pkg.sv
package sgc_pkg;
  localparam int FIELD_W = 5;

  typedef struct packed {
    logic               shift;      // sample accepted this cycle
    logic               useSample;  // delayed sample is real, else taken as zero
    logic               push;       // hand one symbol to the coder
    logic               isRes;      // symbol is the latched residual
    logic [FIELD_W-1:0] fieldVal;   // run-length field value
  } strobe_t;
endpackage

// File: rtl/sgc_ctrl.sv
module sgc_ctrl
  import sgc_pkg::*;
#(
  parameter int WIN_LEN = 64
) (
  input  logic    clk,
  input  logic    rst_n,
  input  logic    inValid,
  input  logic    inSpike,
  input  logic    cfgNear,
  input  logic    symReady,
  output logic    inReady,
  output strobe_t st
);
  localparam int RUN_W = 3*FIELD_W - 1;
  localparam int WC_W  = $clog2(WIN_LEN);
  localparam logic [RUN_W-1:0] SHORT_LIM = RUN_W'(1) << (2*FIELD_W - 1);

  typedef enum logic [2:0] {S_IDLE, S_F0, S_F1, S_F2, S_RES} state_t;

  state_t           state;
  logic [WC_W-1:0]  winCnt;
  logic [RUN_W-1:0] runCnt, runHold;
  logic             longHold, effNear;
  logic             accept, modeNow, startWin, inWin;

  assign accept   = (state == S_IDLE) && inValid;
  assign modeNow  = (winCnt == '0) ? cfgNear : effNear;
  assign startWin = modeNow && (winCnt == '0) && inSpike;
  assign inWin    = modeNow && (startWin || (winCnt != '0));
  assign inReady  = (state == S_IDLE);

  always_comb begin
    st.shift     = accept;
    st.useSample = !modeNow || inWin;
    st.push      = (state != S_IDLE) && symReady;
    st.isRes     = (state == S_RES);
    case (state)
      S_F0:    st.fieldVal = longHold ? {1'b1, runHold[3*FIELD_W-2:2*FIELD_W]}
                                      : {1'b0, runHold[2*FIELD_W-2:FIELD_W]};
      S_F1:    st.fieldVal = longHold ? runHold[2*FIELD_W-1:FIELD_W]
                                      : runHold[FIELD_W-1:0];
      S_F2:    st.fieldVal = runHold[FIELD_W-1:0];
      default: st.fieldVal = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state    <= S_IDLE;
      winCnt   <= '0;
      runCnt   <= '0;
      runHold  <= '0;
      longHold <= 1'b0;
      effNear  <= 1'b0;
    end else begin
      case (state)
        S_IDLE: if (accept) begin
          effNear <= modeNow;
          if (startWin) begin
            winCnt   <= WC_W'(WIN_LEN - 1);
            runHold  <= runCnt;
            longHold <= (runCnt >= SHORT_LIM);
            runCnt   <= '0;
            state    <= S_F0;
          end else if (inWin) begin
            winCnt <= winCnt - 1'b1;
            state  <= S_RES;
          end else if (modeNow) begin
            runCnt <= (runCnt == '1) ? runCnt : runCnt + 1'b1;
          end else begin
            runCnt <= '0;
            state  <= S_RES;
          end
        end
        S_F0:  if (symReady) state <= S_F1;
        S_F1:  if (symReady) state <= longHold ? S_F2 : S_RES;
        S_F2:  if (symReady) state <= S_RES;
        default: if (symReady) state <= S_IDLE;
      endcase
    end
  end

  a_r9_mode_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (winCnt != '0) |=> $stable(effNear));
  a_r6_window_near: assert property (@(posedge clk) disable iff (!rst_n)
    (winCnt != '0) |-> effNear);
  a_r7_fields_after_start: assert property (@(posedge clk) disable iff (!rst_n)
    (state == S_F0) |-> (winCnt == WC_W'(WIN_LEN - 1)));
endmodule

// File: rtl/sgc_datapath.sv
module sgc_datapath
  import sgc_pkg::*;
#(
  parameter int SAMPLE_W   = 9,
  parameter int HIST_DEPTH = 32,
  parameter int WORD_W     = 16,
  parameter int QMAX       = 16,
  parameter int ADAPT_LEN  = 64,
  parameter int K_INIT     = 2
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic signed [SAMPLE_W-1:0] inSample,
  input  strobe_t                    st,
  input  logic                       outReady,
  output logic                       symReady,
  output logic                       outValid,
  output logic [WORD_W-1:0]          outWord
);
  localparam int RES_W  = SAMPLE_W + 2;
  localparam int CODE_W = QMAX + 1 + RES_W;
  localparam int ACC_W  = WORD_W + CODE_W;
  localparam int CNT_W  = $clog2(ACC_W + 1);
  localparam int AC_W   = $clog2(ADAPT_LEN);
  localparam int ZC_W   = AC_W + 1;

  logic signed [SAMPLE_W-1:0] histLine [HIST_DEPTH];
  logic signed [SAMPLE_W-1:0] delayed, eff, h1, h2;
  logic signed [RES_W-1:0]    resid;
  logic [RES_W-1:0]           mapped, resReg, symVal, quot;
  logic [2:0]                 kReg;
  logic                       esc;
  logic [CODE_W-1:0]          code;
  logic [CNT_W-1:0]           lenVal, accCnt, shAmt;
  logic [ACC_W-1:0]           acc;
  logic [AC_W-1:0]            resCnt;
  logic [ZC_W-1:0]            zeroCnt, zeroNext;

  function automatic logic [2:0] kFromZeros(input logic [ZC_W-1:0] z);
    int zi;
    zi = int'(z);
    if (zi*4 >= 3*ADAPT_LEN)   return 3'd0;
    else if (zi*2 >= ADAPT_LEN)  return 3'd1;
    else if (zi*4 >= ADAPT_LEN)  return 3'd2;
    else if (zi*8 >= ADAPT_LEN)  return 3'd3;
    else if (zi*16 >= ADAPT_LEN) return 3'd4;
    else if (zi*32 >= ADAPT_LEN) return 3'd5;
    else if (zi >= 1)            return 3'd6;
    else                         return 3'd7;
  endfunction

  // second-order prediction on effective samples, zigzag fold
  assign delayed = histLine[HIST_DEPTH-1];
  assign eff     = st.useSample ? delayed : '0;
  assign resid   = RES_W'(eff) - (RES_W'(h1) <<< 1) + RES_W'(h2);
  assign mapped  = resid[RES_W-1] ? {~resid[RES_W-2:0], 1'b1}
                                  : {resid[RES_W-2:0], 1'b0};

  // Golomb-Rice codeword, right-aligned
  assign symVal = st.isRes ? resReg : RES_W'(st.fieldVal);
  assign quot   = symVal >> kReg;
  assign esc    = (quot > RES_W'(QMAX));
  always_comb begin
    if (esc) begin
      code   = {{(QMAX+1){1'b1}}, symVal};
      lenVal = CNT_W'(CODE_W);
    end else begin
      code   = (((CODE_W'(1) << quot) - CODE_W'(1)) << (int'(kReg) + 1))
             | (CODE_W'(symVal) & ((CODE_W'(1) << kReg) - CODE_W'(1)));
      lenVal = CNT_W'(quot) + CNT_W'(kReg) + CNT_W'(1);
    end
  end

  assign symReady = (accCnt < CNT_W'(WORD_W));
  assign outValid = (accCnt >= CNT_W'(WORD_W));
  assign outWord  = acc[ACC_W-1 -: WORD_W];
  assign shAmt    = CNT_W'(ACC_W) - accCnt - lenVal;
  assign zeroNext = zeroCnt + ZC_W'(symVal == '0);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < HIST_DEPTH; i++) histLine[i] <= '0;
      h1 <= '0; h2 <= '0; resReg <= '0;
    end else if (st.shift) begin
      histLine[0] <= inSample;
      for (int i = 1; i < HIST_DEPTH; i++) histLine[i] <= histLine[i-1];
      h2 <= h1;
      h1 <= eff;
      resReg <= mapped;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      acc <= '0; accCnt <= '0;
    end else if (st.push) begin
      acc    <= acc | (ACC_W'(code) << shAmt);
      accCnt <= accCnt + lenVal;
    end else if (outValid && outReady) begin
      acc    <= acc << WORD_W;
      accCnt <= accCnt - CNT_W'(WORD_W);
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      kReg <= 3'(K_INIT); resCnt <= '0; zeroCnt <= '0;
    end else if (st.push && st.isRes) begin
      if (resCnt == AC_W'(ADAPT_LEN - 1)) begin
        kReg    <= kFromZeros(zeroNext);
        resCnt  <= '0;
        zeroCnt <= '0;
      end else begin
        resCnt  <= resCnt + 1'b1;
        zeroCnt <= zeroNext;
      end
    end
  end

  a_r10_hold_word: assert property (@(posedge clk) disable iff (!rst_n)
    (outValid && !outReady) |=> (outValid && $stable(outWord)));
  a_r11_push_room: assert property (@(posedge clk) disable iff (!rst_n)
    st.push |-> symReady);
  a_r5_k_changes_on_residual: assert property (@(posedge clk) disable iff (!rst_n)
    !(st.push && st.isRes) |=> $stable(kReg));
  a_r10_no_pop_on_push: assert property (@(posedge clk) disable iff (!rst_n)
    st.push |-> !outValid);
endmodule

// File: rtl/spike_golomb_compressor.sv
module spike_golomb_compressor
  import sgc_pkg::*;
#(
  parameter int SAMPLE_W   = 9,
  parameter int HIST_DEPTH = 32,
  parameter int WIN_LEN    = 64,
  parameter int WORD_W     = 16,
  parameter int QMAX       = 16,
  parameter int ADAPT_LEN  = 64,
  parameter int K_INIT     = 2
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                inValid,
  output logic                inReady,
  input  logic [SAMPLE_W-1:0] inSample,
  input  logic                inSpike,
  input  logic                cfgNearLossless,
  output logic                outValid,
  input  logic                outReady,
  output logic [WORD_W-1:0]   outWord
);
  strobe_t st;
  logic    symReady;

  sgc_ctrl #(.WIN_LEN(WIN_LEN)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .inValid(inValid), .inSpike(inSpike),
    .cfgNear(cfgNearLossless), .symReady(symReady), .inReady(inReady), .st(st)
  );

  sgc_datapath #(
    .SAMPLE_W(SAMPLE_W), .HIST_DEPTH(HIST_DEPTH), .WORD_W(WORD_W),
    .QMAX(QMAX), .ADAPT_LEN(ADAPT_LEN), .K_INIT(K_INIT)
  ) u_dp (
    .clk(clk), .rst_n(rst_n), .inSample($signed(inSample)), .st(st),
    .outReady(outReady), .symReady(symReady), .outValid(outValid), .outWord(outWord)
  );
endmodule

// File: tb/sim_spike_golomb_compressor.sv
module sim_spike_golomb_compressor;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  logic        rst_n = 1'b0, inValid = 1'b0, inSpike = 1'b0, cfgNear = 1'b0, outReady = 1'b1;
  logic [8:0]  inSample = '0;
  logic        inReady, outValid;
  logic [15:0] outWord;

  spike_golomb_compressor u0 (
    .clk(clk), .rst_n(rst_n), .inValid(inValid), .inReady(inReady),
    .inSample(inSample), .inSpike(inSpike), .cfgNearLossless(cfgNear),
    .outValid(outValid), .outReady(outReady), .outWord(outWord)
  );

  int    errors = 0, checks = 0;
  string curReq = "R1";
  bit    stallOn = 1'b0, finished = 1'b0;
  logic [15:0] lfsr = 16'hACE1;

  // reference model state
  int mHist[32];
  int mH1, mH2, mWin, mRun, mK, mCnt, mZ;
  bit mEff;
  bit mBits[$];
  logic [15:0] expWords[$];

  task automatic check(bit ok, string what, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d", curReq, what, act, exp);
    end
  endtask

  task automatic pushBit(bit b);
    mBits.push_back(b);
    if (mBits.size() == 16) begin
      logic [15:0] w;
      for (int i = 0; i < 16; i++) w[15-i] = mBits.pop_front();
      expWords.push_back(w);
    end
  endtask

  // R4 codeword builder
  task automatic emit(int v);
    int q;
    q = v >> mK;
    if (q > 16) begin
      for (int i = 0; i < 17; i++) pushBit(1'b1);
      for (int i = 10; i >= 0; i--) pushBit(((v >> i) & 1) != 0);
    end else begin
      for (int i = 0; i < q; i++) pushBit(1'b1);
      pushBit(1'b0);
      for (int i = mK - 1; i >= 0; i--) pushBit(((v >> i) & 1) != 0);
    end
  endtask

  function automatic int kOf(int z);
    if (z >= 48) return 0;
    if (z >= 32) return 1;
    if (z >= 16) return 2;
    if (z >= 8)  return 3;
    if (z >= 4)  return 4;
    if (z >= 2)  return 5;
    if (z >= 1)  return 6;
    return 7;
  endfunction

  task automatic emitRes(int v);  // R5 adaptation
    emit(v);
    if (v == 0) mZ++;
    mCnt++;
    if (mCnt == 64) begin mK = kOf(mZ); mZ = 0; mCnt = 0; end
  endtask

  task automatic modelStep(int s, bit spk, bit near);
    int d, e, r, mapped;
    bit modeNow, start, inWin;
    d = mHist[31];                                   // R2 delay
    for (int i = 31; i > 0; i--) mHist[i] = mHist[i-1];
    mHist[0] = s;
    modeNow = (mWin == 0) ? near : mEff;             // R9
    start   = modeNow && (mWin == 0) && spk;         // R6
    inWin   = modeNow && (start || mWin != 0);
    e = (!modeNow || inWin) ? d : 0;
    r = e - 2*mH1 + mH2;                             // R3
    mapped = (r >= 0) ? 2*r : -2*r - 1;
    mH2 = mH1; mH1 = e;
    mEff = modeNow;
    if (!modeNow) mRun = 0;
    if (start) begin                                 // R7
      if (mRun < 512) begin
        emit(mRun >> 5); emit(mRun & 31);
      end else begin
        emit(16 + (mRun >> 10)); emit((mRun >> 5) & 31); emit(mRun & 31);
      end
      mRun = 0; mWin = 63;
      emitRes(mapped);
    end else if (inWin) begin
      mWin--; emitRes(mapped);
    end else if (modeNow) begin
      if (mRun < 16383) mRun++;                      // R8
    end else begin
      emitRes(mapped);
    end
  endtask

  task automatic doReset();
    rst_n = 1'b0; inValid = 1'b0;
    repeat (3) @(posedge clk);
    foreach (mHist[i]) mHist[i] = 0;
    mH1 = 0; mH2 = 0; mWin = 0; mRun = 0; mK = 2; mCnt = 0; mZ = 0; mEff = 1'b0;
    mBits.delete(); expWords.delete();
    @(negedge clk); rst_n = 1'b1;
  endtask

  task automatic send(int s, bit spk);
    @(negedge clk);
    inValid = 1'b1; inSample = s[8:0]; inSpike = spk;
    #1;
    while (!inReady) begin @(negedge clk); #1; end   // R11 hold-off
    modelStep(s, spk, cfgNear);
    @(posedge clk); #1;
    inValid = 1'b0;
  endtask

  task automatic noise(int n, int amp);
    for (int i = 0; i < n; i++) send($urandom_range(2*amp) - amp, 1'b0);
  endtask

  task automatic drain();
    for (int i = 0; i < 3000 && expWords.size() != 0; i++) @(posedge clk);
    @(negedge clk);
    check(expWords.size() == 0, "words left undelivered", expWords.size(), 0);
  endtask

  // scoreboard monitor
  initial forever begin
    @(negedge clk);
    if (stallOn) begin
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      outReady = lfsr[0] & lfsr[3];
    end else outReady = 1'b1;
    #1;
    if (rst_n && outValid && outReady) begin
      if (expWords.size() == 0) check(1'b0, "unexpected word", outWord, 0);
      else begin
        logic [15:0] e;
        e = expWords.pop_front();
        check(outWord === e, "word", outWord, e);
      end
    end
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      errors++; checks++;
      $display("FAIL watchdog %s actual=timeout expected=done", curReq);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    doReset();
    curReq = "R1";
    @(negedge clk); #1;
    check(outValid == 1'b0, "outValid after reset", outValid, 0);
    check(inReady == 1'b1, "inReady after reset", inReady, 1);

    curReq = "R2"; cfgNear = 1'b0;           // zero-filled history then a step
    for (int i = 0; i < 40; i++) send(100, 1'b0);
    noise(30, 5);
    drain();

    doReset(); curReq = "R3"; stallOn = 1'b1;
    noise(200, 20);
    drain();

    doReset(); curReq = "R5"; stallOn = 1'b0;
    for (int i = 0; i < 300; i++) send(7, 1'b0);
    for (int i = 0; i < 100; i++) send(i * 2 - 100, 1'b0);
    noise(150, 60);
    drain();

    doReset(); curReq = "R4";
    for (int i = 0; i < 80; i++) send((i % 2) ? -256 : 255, 1'b0);
    drain();

    doReset(); curReq = "R6"; cfgNear = 1'b1;
    noise(30, 15);
    send(40, 1'b1);
    for (int i = 0; i < 63; i++) send($urandom_range(80) - 40, (i % 9) == 4);
    noise(50, 15);
    send(-30, 1'b1);
    noise(100, 15);
    drain();

    doReset(); curReq = "R7";
    noise(600, 10);
    send(60, 1'b1);
    noise(100, 30);
    noise(100, 10);
    send(20, 1'b1);
    noise(100, 10);
    drain();

    doReset(); curReq = "R8";
    noise(16500, 10);
    send(90, 1'b1);
    noise(100, 30);
    drain();

    doReset(); curReq = "R9";
    noise(40, 10);
    send(50, 1'b1);
    noise(20, 25);
    cfgNear = 1'b0;                          // takes effect after window closes
    noise(100, 25);
    cfgNear = 1'b1;
    noise(20, 10);
    send(-50, 1'b1);
    noise(100, 20);
    drain();

    doReset(); curReq = "R10"; cfgNear = 1'b0; stallOn = 1'b1;
    noise(200, 250);
    drain();

    doReset(); curReq = "R11"; cfgNear = 1'b1;
    noise(20, 10);
    send(10, 1'b1);
    noise(120, 200);
    send(-10, 1'b1);
    noise(100, 200);
    drain();

    finished = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule